// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal request port and an external asynchronous static RAM of 131,072 bytes. Each accepted request is a single read or a single write of one 8-bit word at a 17-bit address. The controller produces the memory's active-low chip select, output enable and write strobe, and it drives the memory's shared data bus through a separate data output and drive-enable pair. The pad-level three-state buffers sit outside the block.

All memory timing is set by nanosecond parameters. At elaboration each value is turned into a whole number of clock cycles, rounded up, using a clock period parameter. A write holds the strobe low long enough to cover the pulse width, the address and data setup to the end of the write, and the write cycle time. A read holds the select and output enable low for the access time. The data is captured on the edge that ends that count and is returned with a one-cycle valid pulse.

After every read the controller keeps the memory deselected for a turnaround window. This gives the memory's outputs time to float before the controller may drive the bus again. A new request is taken only when the controller is idle.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and after its release, chip select, output enable and write strobe are all high, the drive-enable is low, the read-valid pulse is low and the request ready signal is high.
- R2: A read request accepted on a clock edge (valid and ready both high) sets chip select low, output enable low and the write strobe high from that edge, with the request address on the address pins.
- R3: A write request accepted on a clock edge sets chip select low, the write strobe low and output enable high from that edge, with drive-enable high and the request data on the data output for the whole strobe.
- R4: The write strobe stays low for exactly WR_CYC cycles, where WR_CYC is the largest of ceil(T/period) over the pulse width, address setup to write end, data setup to write end and write cycle time, each with a minimum of 1.
- R5: The write strobe never rises after chip select. Both rise on the same edge, and drive-enable falls on that edge.
- R6: Drive-enable is high only while chip select and the write strobe are low and output enable is high.
- R7: After a read, chip select and output enable stay high for TA_CYC = ceil(turn-off time / period) cycles with ready low. The controller's drivers never overlap the memory's output drive.
- R8: Read data is captured on the edge that ends RD_CYC = ceil(access time / period) cycles of the read. The read-valid pulse is high for exactly one cycle, starting RD_CYC edges after the accepting edge, and carries the word stored at the address.
- R9: Ready is high only when the controller is idle. In that state all three enables are high and drive-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the memory bus |

## Verification
With the default 4 ns period, the bench derives 3 strobe cycles, 3 access cycles and 2 turnaround cycles from the nanosecond values. Results are sampled on falling edges, counted from the rising edge that accepts a request. The enables are checked on the first falling edge after acceptance. The strobe length is counted over the falling edges that see it low. The read-valid pulse is due on the (RD_CYC+1)-th falling edge and must be gone on the next one. Ready must return exactly TA_CYC falling edges after the pulse. A memory model with delayed data valid and delayed output turn-off catches early capture and any bus overlap.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_TURN  = 2'd3
    } ctl_state_e;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int WR_CYC = 3,
    parameter int RD_CYC = 3,
    parameter int TA_CYC = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              cap_en
);

    typedef struct packed {
        ctl_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdat;
        logic                ce_n;
        logic                oe_n;
        logic                we_n;
        logic                dq_oe;
    } seq_s;

    seq_s r_q, r_d;

    always_comb begin
        r_d    = r_q;
        cap_en = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.ce_n = 1'b0;
                    if (req_write) begin
                        r_d.st    = ST_WRITE;
                        r_d.we_n  = 1'b0;
                        r_d.dq_oe = 1'b1;
                        r_d.wdat  = req_wdata;
                        r_d.cnt   = CNT_W'(WR_CYC - 1);
                    end else begin
                        r_d.st   = ST_READ;
                        r_d.oe_n = 1'b0;
                        r_d.cnt  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WRITE: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_IDLE;
                    r_d.ce_n  = 1'b1;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_READ: begin
                if (r_q.cnt == '0) begin
                    cap_en   = 1'b1;
                    r_d.st   = ST_TURN;
                    r_d.ce_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.cnt  = CNT_W'(TA_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.addr  <= '0;
            r_q.wdat  <= '0;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.dq_oe <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_dq_out = r_q.wdat;
    assign mem_dq_oe  = r_q.dq_oe;

    // strobe-length watcher for the pulse-width check
    logic [CNT_W:0] we_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_q <= '0;
        end else if (mem_we_n) begin
            we_low_q <= '0;
        end else if (we_low_q != '1) begin
            we_low_q <= we_low_q + 1'b1;
        end
    end

    a_r2_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    a_r4_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_q == (CNT_W+1)'(WR_CYC)));

    a_r5_we_not_after_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> (mem_we_n && !mem_dq_oe));

    a_r6_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_ce_n && !mem_we_n && mem_oe_n));

    a_r7_no_drive_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_oe_n) |-> !mem_dq_oe);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

// File: rtl/sram_ctl_rdpath.sv
module sram_ctl_rdpath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } rd_s;

    rd_s p_q, p_d;

    always_comb begin
        p_d     = p_q;
        p_d.vld = cap_en;
        if (cap_en) begin
            p_d.dat = dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rd_valid = p_q.vld;
    assign rd_data  = p_q.dat;

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> $stable(rd_data));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 4,
    parameter int T_WC_NS   = 10,
    parameter int T_WP_NS   = 7,
    parameter int T_AW_NS   = 7,
    parameter int T_DS_NS   = 5,
    parameter int T_AA_NS   = 10,
    parameter int T_HZ_NS   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int WR_CYC = int'(max_u(max_u(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                       max_u(ns_to_cyc(T_DS_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS))));
    localparam int RD_CYC = int'(ns_to_cyc(T_AA_NS, CLK_NS));
    localparam int TA_CYC = int'(ns_to_cyc(T_HZ_NS, CLK_NS));
    localparam int MAX_CYC = int'(max_u(max_u(WR_CYC, RD_CYC), TA_CYC));
    localparam int CNT_W  = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic cap_en;

    sram_ctl_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WR_CYC (WR_CYC),
        .RD_CYC (RD_CYC),
        .TA_CYC (TA_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .cap_en     (cap_en)
    );

    sram_ctl_rdpath #(
        .DATA_W (DATA_W)
    ) u_rdpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .dq_in    (mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

    localparam int CLK_PERIOD = 4;
    localparam int T_WC = 10, T_WP = 7, T_AW = 7, T_DS = 5, T_AA = 10, T_HZ = 5;

    function automatic int up_div(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    localparam int EXP_WR = 3; // ceil over 7,7,5,10 ns at 4 ns
    localparam int EXP_RD = 3; // ceil(10/4)
    localparam int EXP_TA = 2; // ceil(5/4)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctl u_sram_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem_arr [int];
    logic [7:0] exp_arr [int];

    function automatic logic [7:0] mem_get(input int k);
        return mem_arr.exists(k) ? mem_arr[k] : 8'h00;
    endfunction

    function automatic logic [7:0] exp_get(input int k);
        return exp_arr.exists(k) ? exp_arr[k] : 8'h00;
    endfunction

    logic rd_cond, wr_cond, act_dly, mem_active;
    logic [7:0] rd_dly = 8'hEE;
    assign rd_cond    = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign wr_cond    = !mem_ce_n && !mem_we_n;
    assign mem_active = rd_cond || act_dly;
    assign mem_dq_in  = mem_active ? rd_dly : 8'hEE;

    initial act_dly = 1'b0;
    always @(rd_cond or mem_addr) rd_dly <= #(T_AA) (rd_cond ? mem_get(int'(mem_addr)) : 8'hEE);
    always @(rd_cond) act_dly <= #(T_HZ) rd_cond;

    logic        wr_prev = 1'b0;
    int          wr_len = 0;
    logic [16:0] wl_addr;
    logic [7:0]  wl_data;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe) chk(!mem_active, "R7 bus overlap", 1, 0);
            if (mem_dq_oe) chk(wr_cond && mem_oe_n, "R6 drive only in write", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b001);
            if (mem_ce_n && !mem_we_n) chk(1'b0, "R5 strobe after select", 1, 0);
            if (wr_cond) begin
                wl_addr = mem_addr;
                wl_data = mem_dq_oe ? mem_dq_out : 8'hEE;
                wr_len++;
            end else if (wr_prev) begin
                mem_arr[int'(wl_addr)] = wl_data;
                chk(wr_len * CLK_PERIOD >= T_WP, "R4 strobe width ns", wr_len * CLK_PERIOD, T_WP);
                wr_len = 0;
            end
            wr_prev = wr_cond;
        end
    end

    // ---------------- request tasks ----------------
    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        int n;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_ce_n && !mem_we_n && mem_oe_n, "R3 write pins", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b010);
        chk(mem_dq_oe && mem_dq_out == d && mem_addr == a, "R3 write data/addr", int'(mem_dq_out), int'(d));
        n = 0;
        while (!mem_we_n && n < 50) begin
            chk(mem_dq_out == d && mem_dq_oe, "R3 data held", int'(mem_dq_out), int'(d));
            n++;
            @(negedge clk);
        end
        chk(n == EXP_WR, "R4 strobe cycles", n, EXP_WR);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R9 idle after write", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
        exp_arr[int'(a)] = d;
    endtask

    task automatic do_read(input logic [16:0] a);
        int k;
        logic [7:0] e;
        e = exp_get(int'(a));
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_ce_n && !mem_oe_n && mem_we_n && mem_addr == a, "R2 read pins",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
        k = 1;
        while (!rd_valid && k < 50) begin
            chk(!req_ready, "R9 busy in read", int'(req_ready), 0);
            k++;
            @(negedge clk);
        end
        chk(k == EXP_RD + 1, "R8 read latency", k, EXP_RD + 1);
        chk(rd_data == e, "R8 read data", int'(rd_data), int'(e));
        for (int i = 0; i < EXP_TA - 1; i++) begin
            @(negedge clk);
            chk(!req_ready && mem_ce_n && mem_oe_n, "R7 turnaround held", int'(req_ready), 0);
            if (i == 0) chk(!rd_valid, "R8 pulse one cycle", int'(rd_valid), 0);
        end
        @(negedge clk);
        chk(req_ready, "R7 turnaround length", int'(req_ready), 1);
        if (EXP_TA == 1) chk(!rd_valid, "R8 pulse one cycle", int'(rd_valid), 0);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    logic [16:0] pool [32];
    int unsigned seed_dummy;

    initial begin
        seed_dummy = $urandom(32'd1234);
        chk(up_div(T_AA) == EXP_RD && up_div(T_HZ) == EXP_TA, "R8 bench cycle math", up_div(T_AA), EXP_RD);
        chk(max4(up_div(T_WP), up_div(T_AW), up_div(T_DS), up_div(T_WC)) == EXP_WR, "R4 bench cycle math",
            max4(up_div(T_WP), up_div(T_AW), up_div(T_DS), up_div(T_WC)), EXP_WR);
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid, "R1 reset outputs",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 5'b11100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 after reset",
            {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b11110);

        // directed corners
        do_write(17'h00000, 8'hA5);
        do_write(17'h1FFFF, 8'h5A);
        do_read(17'h00000);
        do_read(17'h1FFFF);
        do_read(17'h0BEEF);             // never written
        do_write(17'h1FFFF, 8'hC3);      // write right after read
        do_read(17'h1FFFF);
        do_write(17'h00001, 8'h00);
        do_write(17'h00001, 8'hFF);      // back-to-back writes
        do_read(17'h00001);

        // random fill and readback
        for (int i = 0; i < 32; i++) begin
            pool[i] = 17'($urandom);
            do_write(pool[i], 8'($urandom));
        end
        for (int i = 31; i >= 0; i--) do_read(pool[i]);

        // random mixed traffic
        for (int i = 0; i < 120; i++) begin
            int j;
            j = int'($urandom % 32);
            if ($urandom % 2 == 0) do_write(pool[j], 8'($urandom));
            else                   do_read(pool[j]);
        end

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule